// File: doc/BRIEF.md
# Directory Data-Response Scheduler

This block sits inside a coherence directory and decides when the answer to a memory-bound data request is due. Each request names a block and the node that asked for it. On acceptance the block is looked up in a small direct-mapped residency tag store. If the block is resident, the answer is scheduled after a short hit latency. If it is not, the answer is scheduled after the full memory latency, and the same lookup installs the block.

When the free-running cycle count reaches the due time, the block pulses a response that carries the latched node and block. A pending-miss flag records whether that response stands for a memory access, and the memory-read counter advances only when such a response is issued. Only one request is serviced at a time. With the tag store sized to zero, every request takes the memory latency and counts one memory read, which is plain fixed-latency memory behaviour.

Top module: `dir_rsp_sched`

## Requirements
- R1: After reset, req_ready is high, rsp_valid is low, and mem_reads, store_hits and store_misses are all zero.
- R2: Each accepted request (req_valid and req_ready high at a rising edge) performs exactly one lookup, so store_hits plus store_misses grows by one at that edge.
- R3: A lookup that finds the block resident raises rsp_valid after exactly HIT_LAT rising edges, counting the accepting edge, and never changes mem_reads.
- R4: A lookup that misses raises rsp_valid after exactly MEM_LAT rising edges, counting the accepting edge, and installs the block so that the next request for the same block hits.
- R5: mem_reads grows by one at the rising edge that ends a response cycle, and only when that response came from a miss. It changes at no other time.
- R6: While rsp_valid is high, rsp_node and rsp_block equal the node and block of the accepted request.
- R7: From the accepting edge until the response cycle ends, req_ready is low, and any request offered in that time is ignored: no counter changes and the pending response is unaltered.
- R8: rsp_valid is high for exactly one cycle, and req_ready is high again in the following cycle.
- R9: The tag store is direct-mapped, and the set is the block number modulo SETS. A block that maps to an occupied set with a different block replaces it, so the replaced block misses on its next request.
- R10: With SETS = 0, every request takes MEM_LAT, counts one memory read, and store_hits stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Scheduler idle, request can be taken |
| req_block | input | BLK_W | Block number of the request |
| req_node | input | NODE_W | Requesting node |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_node | output | NODE_W | Target node of the response |
| rsp_block | output | BLK_W | Block of the response |
| mem_reads | output | CNT_W | Responses that needed memory |
| store_hits | output | CNT_W | Tag-store lookups that hit |
| store_misses | output | CNT_W | Tag-store lookups that missed |

## Verification
The bench builds two instances. The first has four sets, a hit latency of 3 and a memory latency of 12, so a short run covers exact edge counts for both paths, a set conflict between blocks 9 and 1, and a request offered while the scheduler is busy. The second has SETS = 0 with the same latencies, so it shows that the disabled store falls back to fixed memory timing and counts every memory read.

// File: rtl/dir_rsp_sched.sv
module dir_rsp_sched #(
  parameter int BLK_W   = 16,
  parameter int NODE_W  = 3,
  parameter int SETS    = 8,
  parameter int HIT_LAT = 10,
  parameter int MEM_LAT = 100,
  parameter int CNT_W   = 16,
  parameter int CYC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BLK_W-1:0]  req_block,
  input  logic [NODE_W-1:0] req_node,
  output logic              rsp_valid,
  output logic [NODE_W-1:0] rsp_node,
  output logic [BLK_W-1:0]  rsp_block,
  output logic [CNT_W-1:0]  mem_reads,
  output logic [CNT_W-1:0]  store_hits,
  output logic [CNT_W-1:0]  store_misses
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

  logic [CYC_W-1:0]  cyc, due;
  logic              busy, pend_miss, hit;
  logic [NODE_W-1:0] node_q;
  logic [BLK_W-1:0]  blk_q;

  wire accept = req_valid && !busy;
  wire fire   = busy && (cyc == due);
  wire [CYC_W-1:0] lat = hit ? CYC_W'(HIT_LAT) : CYC_W'(MEM_LAT);

  assign req_ready = !busy;
  assign rsp_valid = fire;
  assign rsp_node  = node_q;
  assign rsp_block = blk_q;

  generate
    if (SETS == 0) begin : g_off
      assign hit = 1'b0;
    end else begin : g_on
      logic [SETS-1:0]  vld;
      logic [BLK_W-1:0] tags [SETS];
      wire  [IDX_W-1:0] idx = IDX_W'(req_block % SETS);

      assign hit = vld[idx] && (tags[idx] == req_block);

      always_ff @(posedge clk) begin
        if (!rst_n)
          vld <= '0;
        else if (accept && !hit)
          vld[idx] <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (accept && !hit)
          tags[idx] <= req_block;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc          <= '0;
      due          <= '0;
      busy         <= 1'b0;
      pend_miss    <= 1'b0;
      node_q       <= '0;
      blk_q        <= '0;
      mem_reads    <= '0;
      store_hits   <= '0;
      store_misses <= '0;
    end else begin
      cyc <= cyc + 1'b1;
      if (accept) begin
        busy      <= 1'b1;
        due       <= cyc + lat;
        node_q    <= req_node;
        blk_q     <= req_block;
        pend_miss <= !hit;
        if (hit) store_hits   <= store_hits + 1'b1;
        else     store_misses <= store_misses + 1'b1;
      end else if (fire) begin
        busy      <= 1'b0;
        pend_miss <= 1'b0;
        if (pend_miss) mem_reads <= mem_reads + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dir_rsp_sched_chk.sv
module dir_rsp_sched_chk #(
  parameter int CNT_W = 16,
  parameter int SETS  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [CNT_W-1:0] mem_reads,
  input logic [CNT_W-1:0] store_hits,
  input logic [CNT_W-1:0] store_misses
);
  wire [CNT_W:0] lookups = {1'b0, store_hits} + {1'b0, store_misses};

  a_r2_one_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> lookups == $past(lookups) + 1'b1);

  a_r7_no_lookup_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> ($stable(store_hits) && $stable(store_misses)));

  a_r7_busy_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r5_reads_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> $stable(mem_reads));

  generate
    if (SETS == 0) begin : g_off_chk
      a_r10_never_hit: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> store_hits == '0);
    end
  endgenerate
endmodule

bind dir_rsp_sched dir_rsp_sched_chk #(.CNT_W(CNT_W), .SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_reads(mem_reads), .store_hits(store_hits),
  .store_misses(store_misses));

// File: tb/dir_rsp_sched_tb.sv
module dir_rsp_sched_tb;
  localparam int HL = 3, ML = 12;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        rv = 0, rdy, sv;
  logic [15:0] rb = 0, sb;
  logic [2:0]  rn = 0, sn;
  logic [15:0] mr, sh, sm;

  logic        o_rv = 0, o_rdy, o_sv;
  logic [15:0] o_rb = 0, o_sb;
  logic [2:0]  o_rn = 0, o_sn;
  logic [15:0] o_mr, o_sh, o_sm;

  int checks = 0, errors = 0;
  bit done = 0;

  dir_rsp_sched #(.SETS(4), .HIT_LAT(HL), .MEM_LAT(ML)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_ready(rdy), .req_block(rb),
    .req_node(rn), .rsp_valid(sv), .rsp_node(sn), .rsp_block(sb),
    .mem_reads(mr), .store_hits(sh), .store_misses(sm));

  dir_rsp_sched #(.SETS(0), .HIT_LAT(HL), .MEM_LAT(ML)) u_dut_off (
    .clk(clk), .rst_n(rst_n), .req_valid(o_rv), .req_ready(o_rdy), .req_block(o_rb),
    .req_node(o_rn), .rsp_valid(o_sv), .rsp_node(o_sn), .rsp_block(o_sb),
    .mem_reads(o_mr), .store_hits(o_sh), .store_misses(o_sm));

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic request(input int blk, input int node, input bit exp_hit, input bit poke);
    int mr0, sh0, sm0, n;
    int lat = exp_hit ? HL : ML;
    @(negedge clk);
    mr0 = mr; sh0 = sh; sm0 = sm;
    check(rdy == 1, "R7 ready before request", rdy, 1);
    rv = 1; rb = 16'(blk); rn = 3'(node);
    @(posedge clk);
    @(negedge clk);
    rv = 0;
    check(sh + sm == sh0 + sm0 + 1, "R2 one lookup", sh + sm, sh0 + sm0 + 1);
    check(sh == sh0 + (exp_hit ? 1 : 0), exp_hit ? "R3 hit counted" : "R4 miss counted",
          sh, sh0 + (exp_hit ? 1 : 0));
    check(rdy == 0, "R7 ready low while busy", rdy, 0);
    if (poke) begin
      rv = 1; rb = 16'(blk + 1); rn = 3'(node + 1);
      @(posedge clk);
      @(negedge clk);
      rv = 0;
      check(sh + sm == sh0 + sm0 + 1, "R7 busy request ignored", sh + sm, sh0 + sm0 + 1);
      n = 2;
    end else n = 1;
    while (!sv && n < 1000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    check(n == lat, exp_hit ? "R3 hit latency" : "R4 miss latency", n, lat);
    check(sn == 3'(node), "R6 response node", sn, node);
    check(sb == 16'(blk), "R6 response block", sb, blk);
    check(mr == mr0, "R5 no read before response", mr, mr0);
    @(posedge clk);
    @(negedge clk);
    check(sv == 0, "R8 single-cycle pulse", sv, 0);
    check(rdy == 1, "R8 ready after response", rdy, 1);
    check(mr == mr0 + (exp_hit ? 0 : 1), exp_hit ? "R3 hit no memory read" : "R5 miss counted on response",
          mr, mr0 + (exp_hit ? 0 : 1));
  endtask

  task automatic request_off(input int blk, input int exp_reads);
    int n = 1;
    @(negedge clk);
    o_rv = 1; o_rb = 16'(blk); o_rn = 3'd5;
    @(posedge clk);
    @(negedge clk);
    o_rv = 0;
    while (!o_sv && n < 1000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    check(n == ML, "R10 disabled store latency", n, ML);
    @(posedge clk);
    @(negedge clk);
    check(o_mr == 16'(exp_reads), "R10 disabled store memory reads", o_mr, exp_reads);
    check(o_sh == 0, "R10 disabled store never hits", o_sh, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rdy == 1, "R1 reset ready", rdy, 1);
    check(sv == 0, "R1 reset rsp_valid", sv, 0);
    check(mr == 0 && sh == 0 && sm == 0, "R1 reset counters", mr + sh + sm, 0);
    request(5, 2, 0, 0);
    request(5, 6, 1, 0);
    request(9, 1, 0, 0);
    request(1, 3, 0, 0);
    request(9, 4, 0, 0);
    request(9, 0, 1, 0);
    request(22, 7, 0, 1);
    request(23, 2, 0, 0);
    request(22, 1, 1, 1);
    check(mr == 6 && sh == 3 && sm == 6, "R9 final counters", mr * 256 + sh * 16 + sm, 6 * 256 + 3 * 16 + 6);
    request_off(5, 1);
    request_off(5, 2);
    finish_run();
  end
endmodule